// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two sampled USB data lines into a stream of received bytes. It hunts for the start of a packet, locks its bit-centre sampling to the line transitions, and decodes the NRZI signalling. It drops the stuffed bits, builds each byte with the least significant bit first, and presents every completed byte on a one-cycle strobe. An SE0 (both lines low) in a bit period ends the packet. The receiver then reports how many bytes it stored and whether the packet was cut short by a full buffer, a stuffing violation or a partial final byte.

The system clock oversamples the 1.5 Mbit/s line rate by a ratio that need not be a whole number: at 20 MHz it is about 13.33 clocks per bit. A fractional phase accumulator produces ticks at eight times the bit rate. A three-bit phase counter that restarts on every line edge picks the sample point near the centre of each bit. PID decoding, CRC checking and the analog front end belong to other blocks.

Top module: `usbLsRx`

## Requirements
- R1: After reset, byteValid, pktEnd, byteCount, errOverflow, errStuff and errFrame are all 0.
- R2: Line state J is dp=0 with dm=1 and K is dp=1 with dm=0. A J-to-K change starts sync. Sync ends when two K bit periods follow each other. Two J bit periods in a row during sync send the receiver back to hunting, and such a sequence produces no byteValid and no pktEnd.
- R3: A data bit decodes as 1 when the sampled line state equals the previous bit period's state and as 0 when it differs. Bytes are assembled least significant bit first. Each completed byte appears on byteData together with a one-cycle byteValid pulse.
- R4: After six consecutive decoded 1 bits, the next bit period is a stuffed bit. It updates the line history, adds no data bit, and restarts the run. The closing K-K of sync counts as the first 1 of a run. Runs carry across byte boundaries.
- R5: An SE0 sampled in a bit period ends the packet with a one-cycle pktEnd pulse. At that pulse, byteCount holds the number of bytes delivered in the packet. The three error flags are rewritten at every pktEnd and hold their values until the next one, so a clean packet leaves them all at 0.
- R6: A packet longer than BUF_DEPTH bytes (default 12) delivers only BUF_DEPTH bytes. The rest of the packet is ignored, and pktEnd comes with errOverflow=1.
- R7: A decoded 1 in a stuffed-bit position aborts the packet. No further bytes are delivered, and pktEnd comes with errStuff=1.
- R8: An SE0 that arrives when the number of data bits is not a multiple of eight gives errFrame=1 at pktEnd.
- R9: Bytes decode correctly at the default 20 MHz clock when individual bit periods last 13 or 14 clocks in either order of the 13-13-14 pattern. This includes runs of seven bit periods without a line transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the line |
| rst | input | 1 | Synchronous reset, active high |
| dp | input | 1 | Sample of the D+ line |
| dm | input | 1 | Sample of the D- line |
| byteValid | output | 1 | One-cycle strobe for a received byte |
| byteData | output | 8 | Received byte, valid with byteValid |
| pktEnd | output | 1 | One-cycle strobe at end of packet |
| byteCount | output | $clog2(BUF_DEPTH+1) | Bytes delivered in the current packet |
| errOverflow | output | 1 | Last packet exceeded the buffer |
| errStuff | output | 1 | Last packet had a stuffing violation |
| errFrame | output | 1 | Last packet ended on a partial byte |

## Verification
Every cycle, the assertions check four rules. Sample strobes never arrive back to back. A byte is only stored on the eighth bit of a shift. The byte count never passes the buffer depth, and the ones run never exceeds six. The error flags change only with pktEnd, and the two abort causes never appear together. Only the bench scenarios can show the rest: the NRZI decoding and unstuffing give the right byte values, sampling holds up under 13/14-clock bit jitter, a broken sync is rejected, and each abort cause raises the right flag with the right number of bytes delivered.

// File: rtl/usbLsRxPkg.sv
package usbLsRxPkg;

  localparam int ByteBits = 8;
  localparam int OverSample = 8;

  localparam logic [1:0] LineJ   = 2'b01;
  localparam logic [1:0] LineK   = 2'b10;
  localparam logic [1:0] LineSe0 = 2'b00;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_SYNC,
    ST_DATA,
    ST_DRAIN
  } rxState_e;

  typedef struct packed {
    logic startPkt;
    logic shiftEn;
    logic shiftVal;
    logic storeByte;
  } rxCtrl_t;

endpackage

// File: rtl/usbRxDatapath.sv
module usbRxDatapath
  import usbLsRxPkg::*;
#(
  parameter int CLK_HZ    = 20_000_000,
  parameter int BIT_HZ    = 1_500_000,
  parameter int BUF_DEPTH = 12,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dp,
  input  logic                 dm,
  input  rxCtrl_t              ctrl,
  output logic                 sampleStb,
  output logic [1:0]           sampleLine,
  output logic [2:0]           bitIdx,
  output logic [CNT_W-1:0]     byteCount,
  output logic                 byteValid,
  output logic [ByteBits-1:0]  byteData
);

  localparam int STEP  = BIT_HZ * OverSample;
  localparam int ACC_W = $clog2(CLK_HZ + STEP + 1);
  localparam int PH_W  = $clog2(OverSample);
  localparam logic [ACC_W-1:0] STEP_V  = ACC_W'(STEP);
  localparam logic [ACC_W-1:0] LIMIT_V = ACC_W'(CLK_HZ);
  localparam logic [PH_W-1:0]  CENTER  = PH_W'(OverSample / 2 - 1);
  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(BUF_DEPTH);

  logic [1:0] syncA, syncB, lineDly;
  logic lineEdge;
  logic [ACC_W-1:0] acc, accSum;
  logic tick;
  logic [PH_W-1:0] phase;
  logic [ByteBits-1:0] shiftReg, shiftNext;

  assign lineEdge  = (syncB != lineDly);
  assign accSum    = acc + STEP_V;
  assign tick      = (accSum >= LIMIT_V);
  assign shiftNext = {ctrl.shiftVal, shiftReg[ByteBits-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA   <= LineJ;
      syncB   <= LineJ;
      lineDly <= LineJ;
    end else begin
      syncA   <= {dp, dm};
      syncB   <= syncA;
      lineDly <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      phase      <= '0;
      sampleStb  <= 1'b0;
      sampleLine <= LineJ;
    end else begin
      acc <= tick ? (accSum - LIMIT_V) : accSum;
      if (lineEdge) phase <= '0;
      else if (tick) phase <= phase + 1'b1;
      sampleStb <= tick && !lineEdge && (phase == CENTER);
      if (tick && !lineEdge && (phase == CENTER)) sampleLine <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      bitIdx    <= '0;
      byteCount <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= 1'b0;
      if (ctrl.startPkt) begin
        shiftReg  <= '0;
        bitIdx    <= '0;
        byteCount <= '0;
      end else if (ctrl.shiftEn) begin
        shiftReg <= shiftNext;
        bitIdx   <= bitIdx + 1'b1;
        if (ctrl.storeByte) begin
          byteValid <= 1'b1;
          byteData  <= shiftNext;
          byteCount <= byteCount + 1'b1;
        end
      end
    end
  end

  AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (rst)
    sampleStb |=> !sampleStb); // R9

  AST_STORE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    ctrl.storeByte |-> (ctrl.shiftEn && bitIdx == 3'd7)); // R3

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
    byteCount <= DEPTH_V); // R6

endmodule

// File: rtl/usbRxControl.sv
module usbRxControl
  import usbLsRxPkg::*;
#(
  parameter int BUF_DEPTH = 12,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleStb,
  input  logic [1:0]       sampleLine,
  input  logic [2:0]       bitIdx,
  input  logic [CNT_W-1:0] byteCount,
  output rxCtrl_t          ctrl,
  output logic             pktEnd,
  output logic             errOverflow,
  output logic             errStuff,
  output logic             errFrame
);

  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(BUF_DEPTH);
  localparam logic [2:0] RUN_MAX = 3'd6;

  rxState_e state;
  logic [1:0] prevLine;
  logic [2:0] runOnes;
  logic abortStuff, abortOvf;
  logic isK, isJ, isSe0, bitOne, stuffSlot, lastBit;

  assign isK       = (sampleLine == LineK);
  assign isJ       = (sampleLine == LineJ);
  assign isSe0     = (sampleLine == LineSe0);
  assign bitOne    = (sampleLine == prevLine);
  assign stuffSlot = (runOnes == RUN_MAX);
  assign lastBit   = (bitIdx == 3'd7);

  always_comb begin
    ctrl = '0;
    if (sampleStb) begin
      if (state == ST_SYNC && isK && prevLine == LineK) ctrl.startPkt = 1'b1;
      if (state == ST_DATA && !isSe0 && !stuffSlot) begin
        ctrl.shiftEn   = 1'b1;
        ctrl.shiftVal  = bitOne;
        ctrl.storeByte = lastBit && (byteCount < DEPTH_V);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_HUNT;
      prevLine    <= LineJ;
      runOnes     <= '0;
      abortStuff  <= 1'b0;
      abortOvf    <= 1'b0;
      pktEnd      <= 1'b0;
      errOverflow <= 1'b0;
      errStuff    <= 1'b0;
      errFrame    <= 1'b0;
    end else begin
      pktEnd <= 1'b0;
      if (sampleStb) begin
        prevLine <= sampleLine;
        unique case (state)
          ST_HUNT: begin
            if (isK && prevLine == LineJ) state <= ST_SYNC;
          end
          ST_SYNC: begin
            if (isK) begin
              if (prevLine == LineK) begin
                state      <= ST_DATA;
                runOnes    <= 3'd1;
                abortStuff <= 1'b0;
                abortOvf   <= 1'b0;
              end
            end else if (!isJ || prevLine == LineJ) begin
              state <= ST_HUNT;
            end
          end
          ST_DATA: begin
            if (isSe0) begin
              pktEnd      <= 1'b1;
              errFrame    <= (bitIdx != 3'd0);
              errStuff    <= 1'b0;
              errOverflow <= 1'b0;
              state       <= ST_HUNT;
            end else if (stuffSlot) begin
              runOnes <= '0;
              if (bitOne) begin
                abortStuff <= 1'b1;
                state      <= ST_DRAIN;
              end
            end else begin
              runOnes <= bitOne ? runOnes + 1'b1 : 3'd0;
              if (lastBit && byteCount == DEPTH_V) begin
                abortOvf <= 1'b1;
                state    <= ST_DRAIN;
              end
            end
          end
          ST_DRAIN: begin
            if (isSe0) begin
              pktEnd      <= 1'b1;
              errFrame    <= 1'b0;
              errStuff    <= abortStuff;
              errOverflow <= abortOvf;
              state       <= ST_HUNT;
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    runOnes <= RUN_MAX); // R4

  AST_FLAGS_AT_END: assert property (@(posedge clk) disable iff (rst)
    !pktEnd |-> $stable({errOverflow, errStuff, errFrame})); // R5

  AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
    pktEnd |=> !pktEnd); // R5

  AST_ONE_ABORT: assert property (@(posedge clk) disable iff (rst)
    !(errStuff && errOverflow)); // R7

endmodule

// File: rtl/usbLsRx.sv
module usbLsRx
  import usbLsRxPkg::*;
#(
  parameter int CLK_HZ    = 20_000_000,
  parameter int BIT_HZ    = 1_500_000,
  parameter int BUF_DEPTH = 12,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dp,
  input  logic             dm,
  output logic             byteValid,
  output logic [7:0]       byteData,
  output logic             pktEnd,
  output logic [CNT_W-1:0] byteCount,
  output logic             errOverflow,
  output logic             errStuff,
  output logic             errFrame
);

  rxCtrl_t ctrl;
  logic sampleStb;
  logic [1:0] sampleLine;
  logic [2:0] bitIdx;

  usbRxDatapath #(
    .CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ), .BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rst(rst), .dp(dp), .dm(dm), .ctrl(ctrl),
    .sampleStb(sampleStb), .sampleLine(sampleLine), .bitIdx(bitIdx),
    .byteCount(byteCount), .byteValid(byteValid), .byteData(byteData)
  );

  usbRxControl #(
    .BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .sampleLine(sampleLine),
    .bitIdx(bitIdx), .byteCount(byteCount), .ctrl(ctrl), .pktEnd(pktEnd),
    .errOverflow(errOverflow), .errStuff(errStuff), .errFrame(errFrame)
  );

endmodule

// File: tb/tb_usbLsRx.sv
module tb_usbLsRx;

  localparam logic [1:0] J = 2'b01;
  localparam logic [1:0] K = 2'b10;
  localparam logic [1:0] SE0 = 2'b00;

  typedef struct packed {
    logic [3:0]  n;
    logic        pat;
    logic [63:0] data;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{4'd3, 1'b0, 64'h00000000005AA5C3},
    '{4'd4, 1'b1, 64'h00000000FFFFFFFF},
    '{4'd2, 1'b0, 64'h0000000000000000},
    '{4'd8, 1'b1, 64'h967FFE8001FC3F7E},
    '{4'd1, 1'b0, 64'h000000000000003F}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dp = 1'b0;
  logic dm = 1'b1;
  logic byteValid, pktEnd, errOverflow, errStuff, errFrame;
  logic [7:0] byteData;
  logic [3:0] byteCount;

  always #4 clk = ~clk;

  usbLsRx dut (
    .clk(clk), .rst(rst), .dp(dp), .dm(dm),
    .byteValid(byteValid), .byteData(byteData), .pktEnd(pktEnd),
    .byteCount(byteCount), .errOverflow(errOverflow),
    .errStuff(errStuff), .errFrame(errFrame)
  );

  int nTests = 0;
  int nFail = 0;
  logic [7:0] rxBuf [0:255];
  int rxN = 0;
  int endN = 0;
  logic capOvf = 1'b0, capStuff = 1'b0, capFrame = 1'b0;
  int capCount = 0;

  always @(negedge clk) begin
    if (byteValid) begin
      rxBuf[rxN[7:0]] <= byteData;
      rxN <= rxN + 1;
    end
    if (pktEnd) begin
      endN     <= endN + 1;
      capOvf   <= errOverflow;
      capStuff <= errStuff;
      capFrame <= errFrame;
      capCount <= int'(byteCount);
    end
  end

  logic [7:0] pkt [0:15];
  int pat = 0;
  int bitNo = 0;
  logic [1:0] cur = J;

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic lineBit(input logic [1:0] ls);
    int per;
    if (pat == 0) per = (bitNo % 3 == 2) ? 14 : 13;
    else          per = (bitNo % 3 == 0) ? 14 : 13;
    bitNo++;
    {dp, dm} = ls;
    repeat (per) @(negedge clk);
  endtask

  task automatic nrzi(input logic b);
    if (!b) cur = (cur == J) ? K : J;
    lineBit(cur);
  endtask

  task automatic sendPacket(input int n, input int p, input bit noStuff, input int extra);
    int ones;
    pat = p;
    repeat (3) lineBit(J);
    lineBit(K); lineBit(J); lineBit(K); lineBit(J);
    lineBit(K); lineBit(J); lineBit(K); lineBit(K);
    cur = K;
    ones = 1;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 8; j++) begin
        nrzi(pkt[i][j]);
        if (pkt[i][j]) ones++; else ones = 0;
        if (!noStuff && ones == 6) begin
          nrzi(1'b0);
          ones = 0;
        end
      end
    end
    for (int e = 0; e < extra; e++) nrzi(e[0]);
    lineBit(SE0); lineBit(SE0);
    repeat (5) lineBit(J);
  endtask

  task automatic expectPacket(input string tag, input int baseR, input int baseE,
                              input int nExp, input bit ovf, input bit stf, input bit frm);
    check({tag, " pktEnd count"}, endN - baseE, 1);
    check({tag, " bytes delivered"}, rxN - baseR, nExp);
    for (int i = 0; i < nExp; i++)
      check({tag, " byte value"}, int'(rxBuf[(baseR + i) % 256]), int'(pkt[i]));
    check({tag, " byteCount"}, capCount, nExp);
    check({tag, " errOverflow"}, int'(capOvf), int'(ovf));
    check({tag, " errStuff"}, int'(capStuff), int'(stf));
    check({tag, " errFrame"}, int'(capFrame), int'(frm));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests + 1, nFail + 1);
    $finish;
  end

  initial begin
    int baseR, baseE;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 byteValid", int'(byteValid), 0);
    check("R1 pktEnd", int'(pktEnd), 0);
    check("R1 byteCount", int'(byteCount), 0);
    check("R1 flags", int'({errOverflow, errStuff, errFrame}), 0);
    repeat (40) @(negedge clk);

    // R3 R4 R5 R9: vector table of clean packets
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < 8; i++) pkt[i] = VEC[v].data[8*i +: 8];
      baseR = rxN; baseE = endN;
      sendPacket(int'(VEC[v].n), int'(VEC[v].pat), 1'b0, 0);
      expectPacket($sformatf("R3/R4/R5/R9 vec%0d", v), baseR, baseE, int'(VEC[v].n), 0, 0, 0);
    end

    // R2: broken sync (J J during sync) yields nothing
    baseR = rxN; baseE = endN;
    pat = 0;
    repeat (3) lineBit(J);
    lineBit(K); lineBit(J); lineBit(K); lineBit(J); lineBit(J);
    repeat (20) lineBit(J);
    check("R2 no pktEnd on broken sync", endN - baseE, 0);
    check("R2 no bytes on broken sync", rxN - baseR, 0);

    // R6: overflow
    for (int i = 0; i < 13; i++) pkt[i] = 8'(i * 17 + 3);
    baseR = rxN; baseE = endN;
    sendPacket(13, 0, 1'b0, 0);
    expectPacket("R6 overflow", baseR, baseE, 12, 1, 0, 0);

    // R7: stuff violation
    pkt[0] = 8'hFF; pkt[1] = 8'hFF;
    baseR = rxN; baseE = endN;
    sendPacket(2, 1, 1'b1, 0);
    expectPacket("R7 stuff error", baseR, baseE, 0, 0, 1, 0);

    // R8: partial final byte
    pkt[0] = 8'hA5;
    baseR = rxN; baseE = endN;
    sendPacket(1, 0, 1'b0, 3);
    expectPacket("R8 framing error", baseR, baseE, 1, 0, 0, 1);

    // R5: flags return to zero on a following clean packet
    pkt[0] = 8'h12; pkt[1] = 8'h34;
    baseR = rxN; baseE = endN;
    sendPacket(2, 1, 1'b0, 0);
    expectPacket("R5 flags cleared", baseR, baseE, 2, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule